// File: doc/BRIEF.md
# Shadowed SRAM Recall and Store Sequencer

This block holds a small static RAM together with a nonvolatile shadow copy, modelled as a second register array. A sequencer moves data between the two. A recall first wipes every RAM location and then loads the shadow contents into the RAM. A store copies the RAM into the shadow. Each transfer handles one location per clock.

Two supply-status inputs drive the sequencer. One reports supply below the reset level, the other reports supply below the switch level. A drop below the reset level arms a recall flag, and reset arms it too. The armed recall starts by itself once the switch-level input clears. Store requests are refused while supply is low or while a recall is still owed. A manual recall that arrives during a store waits and runs straight after it.

The host sees a plain RAM port with a registered read. A busy flag covers every transfer. A sticky error output marks a host write that coincides with the final cycle of a power-up recall.

Top module: `nvsram_shadow`

## Requirements
- R1: A recall writes zero to every RAM location and then copies every shadow location into the RAM. busy_o stays high for exactly 2·2^ADDR_W + restore_dly_i cycles, and afterwards every RAM location reads back the shadow value.
- R2: A recall never alters the shadow array, so repeated recalls each restore the same contents.
- R3: When a recall ends, the next host writes and reads take effect normally.
- R4: While below_switch_i is 1, a store_req_i pulse is ignored: busy_o stays 0 and the shadow array keeps its contents.
- R5: Reset arms the pending-recall flag, and so does any cycle with below_reset_i at 1. The flag stays armed while supply is low, and no recall starts while below_switch_i is 1.
- R6: With the flag armed, the first idle cycle that has both supply inputs at 0 starts a recall and disarms the flag. After it, no further recall starts without a new request.
- R7: If en_i and we_i are both 1 in the last busy cycle of a power-up recall, wr_corrupt_o goes to 1 at the next edge and stays 1 until reset. Its reset value is 0.
- R8: busy_o is 1 during every recall and store. Host writes issued while busy_o is 1 are dropped, and rdata_o holds its value.
- R9: A store_req_i pulse with both supply inputs at 0, no armed recall flag and busy_o at 0 copies every RAM location into the shadow. busy_o is high for 2^ADDR_W cycles, and the RAM is unchanged.
- R10: A recall_req_i pulse received during a store is held. The recall begins in the cycle after the store ends, so busy_o is high for 2^ADDR_W + 2·2^ADDR_W + restore_dly_i cycles in a row.
- R11: A read (en_i=1, we_i=0, busy_o=0) returns the addressed word on rdata_o one clock later. rdata_o resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| below_reset_i | input | 1 | Supply below the reset level |
| below_switch_i | input | 1 | Supply below the switch level |
| store_req_i | input | 1 | Store request strobe |
| recall_req_i | input | 1 | Manual recall request strobe |
| restore_dly_i | input | DLY_W | Extra recall cycles that model the restore time |
| en_i | input | 1 | Host access enable |
| we_i | input | 1 | Host write enable |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| rdata_o | output | DATA_W | Registered read data |
| busy_o | output | 1 | Recall or store in progress |
| wr_corrupt_o | output | 1 | Sticky flag for a write at the end of a power-up recall |

## Verification
The bench builds the block with ADDR_W=4 (16 locations), DATA_W=8 and DLY_W=8, and drives restore_dly_i to 5. With these values a full recall lasts 37 cycles and a store 16. Every location can therefore be written and read back around each transfer. The store-then-queued-recall run of 53 busy cycles and the exact last recall cycle, where a colliding write must raise the error flag, are both short enough to reach cycle-exactly.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_CPY,
    ST_WAIT,
    ST_STORE
  } seq_st_e;
endpackage

// File: rtl/nvsram_supply_mon.sv
module nvsram_supply_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_reset_i,
  input  logic below_switch_i,
  input  logic auto_take_i,
  output logic pending_o,
  output logic auto_ok_o
);
  logic pending_q;

  // armed at reset: power-up counts as a low-supply event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pending_q <= 1'b1;
    else if (below_reset_i) pending_q <= 1'b1;
    else if (auto_take_i)   pending_q <= 1'b0;
  end

  assign pending_o = pending_q;
  assign auto_ok_o = pending_q && !below_switch_i && !below_reset_i;
endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              auto_ok_i,
  input  logic              pending_i,
  input  logic              below_switch_i,
  input  logic              recall_req_i,
  input  logic              store_req_i,
  input  logic [DLY_W-1:0]  dly_i,
  output seq_st_e           state_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              auto_take_o,
  output logic              rcl_last_o,
  output logic              rcl_auto_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  seq_st_e           state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DLY_W-1:0]  dcnt_q;
  logic              q_rcl_q, rcl_auto_q;
  logic              start_rcl, start_store, addr_last, dly_zero, dly_done;

  assign addr_last = (addr_q == LAST_ADDR);
  assign dly_zero  = (dly_i == '0);
  assign dly_done  = (dcnt_q == dly_i - DLY_W'(1));

  always_comb begin
    state_d     = state_q;
    start_rcl   = 1'b0;
    start_store = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (auto_ok_i || recall_req_i) start_rcl = 1'b1;
        else if (store_req_i && !below_switch_i && !pending_i) start_store = 1'b1;
      end
      ST_CLR:  if (addr_last) state_d = ST_CPY;
      ST_CPY:  if (addr_last) state_d = dly_zero ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (dly_done) state_d = ST_IDLE;
      ST_STORE: begin
        if (addr_last) begin
          if (auto_ok_i || q_rcl_q || recall_req_i) start_rcl = 1'b1;
          else state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (start_rcl)   state_d = ST_CLR;
    if (start_store) state_d = ST_STORE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      dcnt_q     <= '0;
      q_rcl_q    <= 1'b0;
      rcl_auto_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // full sweep wraps the address back to zero
      if (state_q == ST_CLR || state_q == ST_CPY || state_q == ST_STORE)
        addr_q <= addr_q + 1'b1;
      dcnt_q <= (state_q == ST_WAIT) ? dcnt_q + 1'b1 : '0;
      if (start_rcl) begin
        q_rcl_q    <= 1'b0;
        rcl_auto_q <= auto_ok_i;
      end else if (state_q == ST_STORE && recall_req_i) begin
        q_rcl_q <= 1'b1;
      end
    end
  end

  assign state_o     = state_q;
  assign addr_o      = addr_q;
  assign auto_take_o = start_rcl && auto_ok_i;
  assign rcl_last_o  = (state_q == ST_CPY && addr_last && dly_zero) ||
                       (state_q == ST_WAIT && dly_done);
  assign rcl_auto_o  = rcl_auto_q;
endmodule

// File: rtl/nvsram_shadow.sv
module nvsram_shadow
  import nvsram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              below_reset_i,
  input  logic              below_switch_i,
  input  logic              store_req_i,
  input  logic              recall_req_i,
  input  logic [DLY_W-1:0]  restore_dly_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              wr_corrupt_o
);
  localparam int DEPTH = 1 << ADDR_W;

  seq_st_e           state;
  logic [ADDR_W-1:0] seq_addr;
  logic              pending, auto_ok, auto_take, rcl_last, rcl_auto;
  logic              host_wr, host_rd, corrupt_q;

  logic [DATA_W-1:0] sram_q [DEPTH];
  logic [DATA_W-1:0] nv_q   [DEPTH];

  nvsram_supply_mon u_supply (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .below_reset_i  (below_reset_i),
    .below_switch_i (below_switch_i),
    .auto_take_i    (auto_take),
    .pending_o      (pending),
    .auto_ok_o      (auto_ok)
  );

  nvsram_seq #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .auto_ok_i      (auto_ok),
    .pending_i      (pending),
    .below_switch_i (below_switch_i),
    .recall_req_i   (recall_req_i),
    .store_req_i    (store_req_i),
    .dly_i          (restore_dly_i),
    .state_o        (state),
    .addr_o         (seq_addr),
    .auto_take_o    (auto_take),
    .rcl_last_o     (rcl_last),
    .rcl_auto_o     (rcl_auto)
  );

  assign busy_o  = (state != ST_IDLE);
  assign host_wr = en_i && we_i && !busy_o;
  assign host_rd = en_i && !we_i && !busy_o;

  always_ff @(posedge clk_i) begin
    unique case (state)
      ST_CLR:  sram_q[seq_addr] <= '0;
      ST_CPY:  sram_q[seq_addr] <= nv_q[seq_addr];
      ST_IDLE: if (host_wr) sram_q[addr_i] <= wdata_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (state == ST_STORE) nv_q[seq_addr] <= sram_q[seq_addr];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (host_rd) rdata_o <= sram_q[addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) corrupt_q <= 1'b0;
    else if (rcl_last && rcl_auto && en_i && we_i) corrupt_q <= 1'b1;
  end

  assign wr_corrupt_o = corrupt_q;
endmodule

// File: rtl/nvsram_shadow_chk.sv
module nvsram_shadow_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              below_reset_i,
  input logic              below_switch_i,
  input logic              store_req_i,
  input logic              recall_req_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              wr_corrupt_o,
  input logic              pending
);
  assert_store_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && store_req_i && below_switch_i && !recall_req_i) |=> !busy_o);

  assert_pending_arm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below_reset_i |=> pending);

  assert_auto_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && pending && !below_switch_i && !below_reset_i) |=> busy_o);

  assert_corrupt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_corrupt_o |=> wr_corrupt_o);

  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rdata_o));

  assert_store_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && store_req_i && !below_switch_i && !below_reset_i && !pending) |=> busy_o);
endmodule

bind nvsram_shadow nvsram_shadow_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .below_reset_i  (below_reset_i),
  .below_switch_i (below_switch_i),
  .store_req_i    (store_req_i),
  .recall_req_i   (recall_req_i),
  .busy_o         (busy_o),
  .rdata_o        (rdata_o),
  .wr_corrupt_o   (wr_corrupt_o),
  .pending        (pending)
);

// File: tb/nvsram_shadow_tb.sv
module nvsram_shadow_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int LW = 8;
  localparam int N = 1 << AW;
  localparam int DLY = 5;
  localparam int RCL_LEN = 2 * N + DLY;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic below_reset_i = 1'b1, below_switch_i = 1'b1;
  logic store_req_i = 1'b0, recall_req_i = 1'b0;
  logic [LW-1:0] restore_dly_i = LW'(DLY);
  logic en_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic busy_o, wr_corrupt_o;

  int checks = 0, errors = 0;
  logic [DW-1:0] sram_m [N];
  logic [DW-1:0] nv_m [N];
  logic [DW-1:0] exp_q [$];
  string tag_q [$];
  logic rd_go = 1'b0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  nvsram_shadow #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(LW)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compare registered read data one edge after each issued read
  initial forever begin
    @(posedge clk_i);
    if (rd_go) begin
      #2;
      check(rdata_o == exp_q[0], tag_q[0], int'(rdata_o), int'(exp_q[0]));
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic do_write(input int a, input logic [DW-1:0] d);
    en_i = 1'b1; we_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    if (!busy_o) sram_m[a] = d;
    @(negedge clk_i);
    en_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic do_read(input int a, input string tag);
    en_i = 1'b1; we_i = 1'b0; addr_i = AW'(a);
    exp_q.push_back(sram_m[a]); tag_q.push_back(tag);
    rd_go = 1'b1;
    @(negedge clk_i);
    en_i = 1'b0; rd_go = 1'b0;
  endtask

  task automatic run_op(input bit is_store, output int n);
    if (is_store) store_req_i = 1'b1; else recall_req_i = 1'b1;
    n = 0;
    forever begin
      @(negedge clk_i);
      store_req_i = 1'b0; recall_req_i = 1'b0;
      if (busy_o) n++; else break;
    end
  endtask

  task automatic fill(input int mul, input int add);
    for (int a = 0; a < N; a++) do_write(a, DW'(a * mul + add));
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < N; a++) do_read(a, tag);
    @(negedge clk_i);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0 && rdata_o == '0, "R11 reset", int'(rdata_o), 0);
    check(wr_corrupt_o == 1'b0, "R7 reset", int'(wr_corrupt_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    check(busy_o == 1'b0, "R5 no recall while supply low", int'(busy_o), 0);
    run_op(1'b1, n);
    check(n == 0, "R4 store refused while low", n, 0);

    // supply recovers: armed recall fires on its own
    below_reset_i = 1'b0; below_switch_i = 1'b0;
    n = 0;
    forever begin
      @(negedge clk_i);
      if (busy_o) n++; else break;
    end
    check(n == RCL_LEN, "R6 power-up recall length", n, RCL_LEN);
    repeat (4) @(negedge clk_i);
    check(busy_o == 1'b0, "R6 flag disarmed", int'(busy_o), 0);

    fill(7, 3);
    read_all("R3 host access after recall");

    run_op(1'b1, n);
    check(n == N, "R9 store length", n, N);
    for (int a = 0; a < N; a++) nv_m[a] = sram_m[a];
    read_all("R9 store leaves RAM intact");

    // write issued during a store is dropped
    store_req_i = 1'b1;
    @(negedge clk_i);
    store_req_i = 1'b0;
    do_write(1, 8'hEE);
    while (busy_o) @(negedge clk_i);
    do_read(1, "R8 write during busy dropped");
    @(negedge clk_i);

    fill(5, 100);
    run_op(1'b0, n);
    check(n == RCL_LEN, "R1 manual recall length", n, RCL_LEN);
    for (int a = 0; a < N; a++) sram_m[a] = nv_m[a];
    read_all("R1 RAM equals shadow");

    fill(3, 50);
    run_op(1'b0, n);
    check(n == RCL_LEN, "R2 repeat recall length", n, RCL_LEN);
    for (int a = 0; a < N; a++) sram_m[a] = nv_m[a];
    read_all("R2 shadow unchanged by recall");

    // store with a recall queued in mid-flight
    fill(11, 9);
    store_req_i = 1'b1;
    n = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk_i);
      store_req_i = 1'b0;
      recall_req_i = (c == 3);
      if (busy_o) n++; else break;
    end
    recall_req_i = 1'b0;
    check(n == N + RCL_LEN, "R10 queued recall back to back", n, N + RCL_LEN);
    for (int a = 0; a < N; a++) nv_m[a] = sram_m[a];
    read_all("R10 data after queued recall");

    // store blocked by switch-level supply only
    fill(13, 1);
    below_switch_i = 1'b1;
    @(negedge clk_i);
    run_op(1'b1, n);
    check(n == 0, "R4 store refused at switch level", n, 0);
    below_switch_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0, "R6 no recall without arm", int'(busy_o), 0);
    run_op(1'b0, n);
    for (int a = 0; a < N; a++) sram_m[a] = nv_m[a];
    read_all("R4 shadow kept after refused store");

    // brown-out rearms; write collides with last recall cycle
    below_reset_i = 1'b1; below_switch_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check(busy_o == 1'b0, "R5 held while low", int'(busy_o), 0);
    check(wr_corrupt_o == 1'b0, "R7 clear before collision", int'(wr_corrupt_o), 0);
    below_reset_i = 1'b0; below_switch_i = 1'b0;
    n = 0;
    for (int c = 0; c < RCL_LEN; c++) begin
      @(negedge clk_i);
      if (busy_o) n++;
    end
    check(n == RCL_LEN, "R5 rearmed recall length", n, RCL_LEN);
    en_i = 1'b1; we_i = 1'b1; addr_i = '0; wdata_i = 8'h55;
    @(negedge clk_i);
    en_i = 1'b0; we_i = 1'b0;
    check(busy_o == 1'b0, "R1 recall ended", int'(busy_o), 0);
    @(negedge clk_i);
    check(wr_corrupt_o == 1'b1, "R7 corrupt flagged", int'(wr_corrupt_o), 1);
    repeat (5) @(negedge clk_i);
    check(wr_corrupt_o == 1'b1, "R7 corrupt sticky", int'(wr_corrupt_o), 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule